// File: doc/BRIEF.md
# Banked DRAM Access Arbiter with Wait-State Insertion

This block sits between one processor access port and a DRAM array split into four banks. A processor cycle opens with an address strobe while the access request is held high. The block then raises the row strobe of the selected bank and, one clock later, the column strobe. It holds the processor with a handshake line until a programmed number of wait states has run. The cycle closes when the processor drops its access request.

A refresh sequencer posts one-cycle refresh pulses. The block holds each pulse until it can serve it, and then performs a row-only refresh on all four banks for a fixed number of clocks. Each bank has its own precharge timer. A new cycle to a bank that was just closed waits until that bank has rested long enough. A cycle to another bank starts at once, so interleaved traffic runs without stalls.

The handshake line is active low and has two selectable meanings. In one mode it is a wait line that is pulled low while the processor must stall. In the other it is an acknowledge that is pulled low when data is ready. A wait-extension input stretches any cycle by whole clocks.

Top module: `dram_bank_arbiter`

## Requirements
- R1: After synchronous reset, all row strobes and the column strobe are off, `hs_n` is high, `rfsh_busy` is low, and every bank precharge timer is expired, so the first access after reset starts on the next edge.
- R2: When the strobe is seen with `acc_req` high, the selected bank is precharged and no refresh wins, `ras_on[bank_sel]` rises on the next clock edge and the other bits stay low. Bank n maps to bit n. Outside refresh, at most one row strobe is on.
- R3: `cas_on` rises one edge after the access row strobe rises. It is never on while no row strobe is on.
- R4: Data-ready is reached cfg_wait_cyc+1 edges after the row strobe rises. Each edge at which `wait_ext` is sampled high while wait states are still pending adds one edge. Data-ready stays until the access ends.
- R5: With `cfg_hs_dtack`=1, `hs_n` is low exactly while data-ready holds. With `cfg_hs_dtack`=0, `hs_n` is low while `acc_req` is high and data-ready does not yet hold; otherwise it is high.
- R6: When `acc_req` is sampled low during an access, the row strobe, the column strobe and data-ready all turn off at that edge.
- R7: After a bank's row strobe falls, that bank's row strobe stays off for at least cfg_pre_cyc+1 clock periods. A new access to the same bank issued right after the end starts exactly cfg_pre_cyc+1 edges later.
- R8: An access to a bank whose timer has expired starts on the next edge, whatever the state of the other banks' timers.
- R9: A refresh turns on all four row strobes and `rfsh_busy` for exactly RFSH_LOW clocks (default 3), with `cas_on` off. It starts only when all banks are precharged. Afterwards every bank observes its precharge time.
- R10: A refresh pulse that arrives while the block is busy is held pending and is served once the block returns to idle. When the block is idle and no access competes, a pulse starts the refresh on the next edge.
- R11: When a pending refresh and a new access compete in the same idle cycle, the access wins unless the refresh age exceeds `cfg_rf_age_lim`. The age is 0 in the pulse cycle and rises by one per edge while pending, saturating at 7. A refresh that wins holds the armed access until the refresh completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hs_dtack | input | 1 | Handshake style: 0 wait line, 1 acknowledge |
| cfg_pre_cyc | input | 2 | Precharge clocks beyond the minimum one |
| cfg_wait_cyc | input | 2 | Base wait states |
| cfg_rf_age_lim | input | 3 | Refresh age above which refresh beats a competing access |
| acc_strobe | input | 1 | Address strobe, latches `bank_sel` |
| acc_req | input | 1 | Access request, held for the whole cycle |
| bank_sel | input | 2 | Bank number |
| rfsh_req | input | 1 | One-cycle refresh pulse |
| wait_ext | input | 1 | Adds a wait state per edge while high |
| ras_on | output | 4 | Row strobes, one per bank, active high |
| cas_on | output | 1 | Column strobe, active high |
| hs_n | output | 1 | Handshake, active low |
| rfsh_busy | output | 1 | Refresh row strobes are on |

## Verification
The assertions assume several things about the inputs. The configuration inputs change only while reset is held. `acc_strobe` is pulsed only while `acc_req` is high. `rfsh_req` is a single-cycle pulse. `acc_req` stays high until the processor chooses to end the cycle. The stimulus meets these assumptions: configuration is applied before every reset, the strobe is held for one clock with the request already high, and refresh is pulsed for one clock. The sweep covers every precharge count, wait count and wait-extension length in both handshake modes, followed by the refresh and competition cases.

// File: rtl/dra_pkg.sv
package dra_pkg;

  // Sequencer states shared by the control path and its checks.
  typedef enum logic [2:0] {
    ST_IDLE,   // nothing in flight
    ST_APRE,   // access accepted, bank still precharging
    ST_ACT,    // access row strobe on, counting wait states
    ST_HOLD,   // data ready, waiting for the request to drop
    ST_RPRE,   // refresh accepted, banks still precharging
    ST_RACT    // refresh row strobes on
  } seq_st_e;

endpackage

// File: rtl/dra_bank_timers.sv
module dra_bank_timers #(
  parameter int NB = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] load,
  input  logic [PW-1:0] pre_cyc,
  output logic [NB-1:0] expired
);

  function automatic logic [PW-1:0] timer_step(input logic [PW-1:0] cur,
                                               input logic          ld,
                                               input logic [PW-1:0] val);
    if (ld) return val;
    if (cur != '0) return cur - PW'(1);
    return cur;
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [PW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= timer_step(cnt, load[g], pre_cyc);
    end
    assign expired[g] = (cnt == '0);
  end

endmodule

// File: rtl/dra_rfsh_arb.sv
module dra_rfsh_arb #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rfsh_req,
  input  logic          take,
  input  logic          acc_go,
  input  logic [AW-1:0] age_lim,
  output logic          rf_win
);

  logic          pend;
  logic [AW-1:0] age;
  logic [AW-1:0] age_now;
  logic          rf_valid;

  function automatic logic [AW-1:0] age_step(input logic [AW-1:0] a);
    return (a == '1) ? a : a + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      age  <= '0;
    end else if (take) begin
      pend <= 1'b0;
      age  <= '0;
    end else if (pend) begin
      age  <= age_step(age);
    end else if (rfsh_req) begin
      pend <= 1'b1;
      age  <= '0;
    end
  end

  assign rf_valid = pend | rfsh_req;
  assign age_now  = pend ? age : '0;
  assign rf_win   = rf_valid & (~acc_go | (age_now > age_lim));

endmodule

// File: rtl/dra_seq.sv
module dra_seq
  import dra_pkg::*;
#(
  parameter int NB       = 4,
  parameter int BW       = 2,
  parameter int WW       = 2,
  parameter int RFSH_LOW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_go,
  input  logic [BW-1:0] acc_bank,
  input  logic          acc_req,
  input  logic          wait_ext,
  input  logic [WW-1:0] wait_cyc,
  input  logic [NB-1:0] bank_exp,
  input  logic          rf_win,
  output logic [NB-1:0] ras_on,
  output logic          cas_on,
  output logic          data_rdy,
  output logic          rf_busy,
  output logic [NB-1:0] pre_load,
  output logic          rf_take,
  output logic          acc_take
);

  localparam int RLW = $clog2(RFSH_LOW + 1);

  seq_st_e        st, nst;
  logic [BW-1:0]  cur_bank, nbank;
  logic [WW-1:0]  wcnt, nwcnt;
  logic [RLW-1:0] rcnt, nrcnt;
  logic [NB-1:0]  ras_q;
  logic           cas_q, rdy_q, busy_q;
  logic           in_acc, nxt_acc;

  function automatic logic [NB-1:0] bank_bit(input logic [BW-1:0] b);
    return NB'(1) << b;
  endfunction

  always_comb begin
    nst      = st;
    nbank    = cur_bank;
    nwcnt    = wcnt;
    nrcnt    = rcnt;
    pre_load = '0;
    rf_take  = 1'b0;
    acc_take = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rf_win) begin
          rf_take = 1'b1;
          if (&bank_exp) begin
            nst   = ST_RACT;
            nrcnt = RLW'(RFSH_LOW - 1);
          end else begin
            nst = ST_RPRE;
          end
        end else if (acc_go) begin
          acc_take = 1'b1;
          nbank    = acc_bank;
          if (bank_exp[acc_bank]) begin
            nst   = ST_ACT;
            nwcnt = wait_cyc;
          end else begin
            nst = ST_APRE;
          end
        end
      end
      ST_APRE: begin
        if (!acc_req) begin
          nst = ST_IDLE;
        end else if (bank_exp[cur_bank]) begin
          nst   = ST_ACT;
          nwcnt = wait_cyc;
        end
      end
      ST_ACT: begin
        if (!acc_req) begin
          nst      = ST_IDLE;
          pre_load = bank_bit(cur_bank);
        end else if (!wait_ext) begin
          if (wcnt == '0) nst = ST_HOLD;
          else            nwcnt = wcnt - WW'(1);
        end
      end
      ST_HOLD: begin
        if (!acc_req) begin
          nst      = ST_IDLE;
          pre_load = bank_bit(cur_bank);
        end
      end
      ST_RPRE: begin
        if (&bank_exp) begin
          nst   = ST_RACT;
          nrcnt = RLW'(RFSH_LOW - 1);
        end
      end
      ST_RACT: begin
        if (rcnt == '0) begin
          nst      = ST_IDLE;
          pre_load = '1;
        end else begin
          nrcnt = rcnt - RLW'(1);
        end
      end
      default: nst = ST_IDLE;
    endcase
  end

  assign in_acc  = (st == ST_ACT) || (st == ST_HOLD);
  assign nxt_acc = (nst == ST_ACT) || (nst == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_bank <= '0;
      wcnt     <= '0;
      rcnt     <= '0;
      ras_q    <= '0;
      cas_q    <= 1'b0;
      rdy_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      st       <= nst;
      cur_bank <= nbank;
      wcnt     <= nwcnt;
      rcnt     <= nrcnt;
      ras_q    <= nxt_acc ? bank_bit(nbank) : ((nst == ST_RACT) ? '1 : '0);
      cas_q    <= in_acc && nxt_acc;
      rdy_q    <= (nst == ST_HOLD);
      busy_q   <= (nst == ST_RACT);
    end
  end

  assign ras_on   = ras_q;
  assign cas_on   = cas_q;
  assign data_rdy = rdy_q;
  assign rf_busy  = busy_q;

endmodule

// File: rtl/dram_bank_arbiter.sv
module dram_bank_arbiter #(
  parameter  int NB       = 4,
  parameter  int PW       = 2,
  parameter  int WW       = 2,
  parameter  int AW       = 3,
  parameter  int RFSH_LOW = 3,
  localparam int BW       = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_hs_dtack,
  input  logic [PW-1:0] cfg_pre_cyc,
  input  logic [WW-1:0] cfg_wait_cyc,
  input  logic [AW-1:0] cfg_rf_age_lim,
  input  logic          acc_strobe,
  input  logic          acc_req,
  input  logic [BW-1:0] bank_sel,
  input  logic          rfsh_req,
  input  logic          wait_ext,
  output logic [NB-1:0] ras_on,
  output logic          cas_on,
  output logic          hs_n,
  output logic          rfsh_busy
);

  // Named internal events, visible to the bound checker.
  logic          armed;
  logic [BW-1:0] bank_q;
  logic          acc_go;
  logic [BW-1:0] acc_bank;
  logic          rf_win;
  logic          rf_take;
  logic          acc_take;
  logic          data_rdy;
  logic [NB-1:0] bank_exp;
  logic [NB-1:0] pre_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      bank_q <= '0;
    end else if (!acc_req || acc_take) begin
      armed  <= 1'b0;
    end else if (acc_strobe) begin
      armed  <= 1'b1;
      bank_q <= bank_sel;
    end
  end

  assign acc_go   = acc_req & (armed | acc_strobe);
  assign acc_bank = acc_strobe ? bank_sel : bank_q;

  dra_bank_timers #(.NB(NB), .PW(PW)) u_timers (
    .clk     (clk),
    .rst     (rst),
    .load    (pre_load),
    .pre_cyc (cfg_pre_cyc),
    .expired (bank_exp)
  );

  dra_rfsh_arb #(.AW(AW)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .rfsh_req (rfsh_req),
    .take     (rf_take),
    .acc_go   (acc_go),
    .age_lim  (cfg_rf_age_lim),
    .rf_win   (rf_win)
  );

  dra_seq #(.NB(NB), .BW(BW), .WW(WW), .RFSH_LOW(RFSH_LOW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .acc_go   (acc_go),
    .acc_bank (acc_bank),
    .acc_req  (acc_req),
    .wait_ext (wait_ext),
    .wait_cyc (cfg_wait_cyc),
    .bank_exp (bank_exp),
    .rf_win   (rf_win),
    .ras_on   (ras_on),
    .cas_on   (cas_on),
    .data_rdy (data_rdy),
    .rf_busy  (rfsh_busy),
    .pre_load (pre_load),
    .rf_take  (rf_take),
    .acc_take (acc_take)
  );

  assign hs_n = cfg_hs_dtack ? ~data_rdy : ~(acc_req & ~data_rdy);

endmodule

// File: rtl/dram_bank_arbiter_chk.sv
module dram_bank_arbiter_chk #(
  parameter int NB       = 4,
  parameter int PW       = 2,
  parameter int RFSH_LOW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_hs_dtack,
  input logic [PW-1:0] cfg_pre_cyc,
  input logic          acc_req,
  input logic [NB-1:0] ras_on,
  input logic          cas_on,
  input logic          hs_n,
  input logic          rfsh_busy,
  input logic          data_rdy
);

  localparam int OW = PW + 1;
  localparam int CW = $clog2(RFSH_LOW + 2);

  logic [CW-1:0] rf_run;

  always_ff @(posedge clk) begin
    if (rst)            rf_run <= '0;
    else if (rfsh_busy) rf_run <= (rf_run == '1) ? rf_run : rf_run + CW'(1);
    else                rf_run <= '0;
  end

  for (genvar g = 0; g < NB; g++) begin : g_gap
    logic [OW-1:0] off_cnt;
    always_ff @(posedge clk) begin
      if (rst)            off_cnt <= '1;
      else if (ras_on[g]) off_cnt <= '0;
      else if (off_cnt != '1) off_cnt <= off_cnt + OW'(1);
    end
    // R7
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ras_on[g]) |-> (off_cnt > OW'(cfg_pre_cyc)));
  end

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    !rfsh_busy |-> $onehot0(ras_on));

  // R3
  cas_row_chk: assert property (@(posedge clk) disable iff (rst)
    cas_on |-> (ras_on != '0));

  // R4
  rdy_cas_chk: assert property (@(posedge clk) disable iff (rst)
    data_rdy |-> cas_on);

  // R5
  ack_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_hs_dtack && !cas_on) |-> hs_n);

  // R6
  end_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_on && !acc_req) |=> ((ras_on == '0) && !cas_on));

  // R9
  rf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rfsh_busy |-> (!cas_on && (&ras_on)));

  // R9
  rf_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rfsh_busy) |-> (rf_run == CW'(RFSH_LOW)));

endmodule

bind dram_bank_arbiter dram_bank_arbiter_chk #(
  .NB(NB), .PW(PW), .RFSH_LOW(RFSH_LOW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_hs_dtack (cfg_hs_dtack),
  .cfg_pre_cyc  (cfg_pre_cyc),
  .acc_req      (acc_req),
  .ras_on       (ras_on),
  .cas_on       (cas_on),
  .hs_n         (hs_n),
  .rfsh_busy    (rfsh_busy),
  .data_rdy     (data_rdy)
);

// File: tb/sim_dram_bank_arbiter.sv
module sim_dram_bank_arbiter;

  localparam int NB = 4;
  localparam int PW = 2;
  localparam int WW = 2;
  localparam int AW = 3;
  localparam int RL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_hs_dtack = 1'b0;
  logic [PW-1:0] cfg_pre_cyc = '0;
  logic [WW-1:0] cfg_wait_cyc = '0;
  logic [AW-1:0] cfg_rf_age_lim = '0;
  logic          acc_strobe = 1'b0;
  logic          acc_req = 1'b0;
  logic [1:0]    bank_sel = '0;
  logic          rfsh_req = 1'b0;
  logic          wait_ext = 1'b0;
  logic [NB-1:0] ras_on;
  logic          cas_on;
  logic          hs_n;
  logic          rfsh_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_bank_arbiter #(.NB(NB), .PW(PW), .WW(WW), .AW(AW), .RFSH_LOW(RL)) u0 (
    .clk(clk), .rst(rst), .cfg_hs_dtack(cfg_hs_dtack), .cfg_pre_cyc(cfg_pre_cyc),
    .cfg_wait_cyc(cfg_wait_cyc), .cfg_rf_age_lim(cfg_rf_age_lim),
    .acc_strobe(acc_strobe), .acc_req(acc_req), .bank_sel(bank_sel),
    .rfsh_req(rfsh_req), .wait_ext(wait_ext), .ras_on(ras_on), .cas_on(cas_on),
    .hs_n(hs_n), .rfsh_busy(rfsh_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    acc_strobe = 1'b0; acc_req = 1'b0; rfsh_req = 1'b0; wait_ext = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  // Row strobe bit for a bank number.
  function automatic int bit_of(input int b);
    return 1 << b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Sweep: handshake mode x precharge x wait states x extension length.
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < 4; w++) begin
          for (int x = 0; x < 3; x++) begin
            int b, nb, fin;
            cfg_hs_dtack = d[0];
            cfg_pre_cyc = p[PW-1:0];
            cfg_wait_cyc = w[WW-1:0];
            cfg_rf_age_lim = 3'd2;
            do_reset();
            chk(ras_on == 0 && !cas_on && hs_n && !rfsh_busy, "R1 reset outputs",
                int'(ras_on), 0);
            b = (p * 3 + w + x) % 4;
            nb = (b + 1) % 4;
            fin = w + x + 2;
            acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'(b); wait_ext = (x > 0);
            for (int t = 1; t <= fin; t++) begin
              bit rdy;
              tick();
              rdy = (t == fin);
              if (t == 1) begin
                chk(int'(ras_on) == bit_of(b), "R2 row strobe of selected bank",
                    int'(ras_on), bit_of(b));
                chk(!cas_on, "R3 column strobe one edge late", int'(cas_on), 0);
                acc_strobe = 1'b0;
              end else begin
                chk(cas_on, "R3 column strobe on", int'(cas_on), 1);
              end
              // R4 ready edge and R5 handshake polarity
              chk(hs_n == (d == 1 ? !rdy : rdy), "R4 R5 handshake timing",
                  int'(hs_n), int'(d == 1 ? !rdy : rdy));
              if (t == x + 1) wait_ext = 1'b0;
            end
            tick();
            chk(hs_n == (d == 0), "R4 ready held", int'(hs_n), int'(d == 0));
            acc_req = 1'b0;
            tick();
            chk(ras_on == 0 && !cas_on && hs_n, "R6 end of access", int'(ras_on), 0);
            // Same bank again right away.
            acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'(b);
            for (int k = 1; k <= p + 1; k++) begin
              tick();
              if (k == 1) acc_strobe = 1'b0;
              chk(int'(ras_on) == (k == p + 1 ? bit_of(b) : 0), "R7 same bank precharge",
                  int'(ras_on), (k == p + 1 ? bit_of(b) : 0));
            end
            acc_req = 1'b0;
            tick();
            chk(ras_on == 0, "R6 second end", int'(ras_on), 0);
            // Other bank immediately, own timer expired.
            acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'(nb);
            tick();
            acc_strobe = 1'b0;
            chk(int'(ras_on) == bit_of(nb), "R8 other bank no delay", int'(ras_on), bit_of(nb));
            acc_req = 1'b0;
            tick();
          end
        end
      end
    end

    // Refresh from idle.
    cfg_hs_dtack = 1'b1; cfg_pre_cyc = 2'd1; cfg_wait_cyc = 2'd1; cfg_rf_age_lim = 3'd2;
    do_reset();
    rfsh_req = 1'b1;
    for (int t = 1; t <= RL + 1; t++) begin
      tick();
      if (t == 1) begin
        rfsh_req = 1'b0;
        chk(ras_on == 4'hF, "R10 idle refresh starts next edge", int'(ras_on), 15);
      end
      chk(int'(ras_on) == (t <= RL ? 15 : 0), "R9 refresh row strobes", int'(ras_on),
          (t <= RL ? 15 : 0));
      chk(rfsh_busy == (t <= RL) && !cas_on, "R9 busy and no column", int'(rfsh_busy),
          int'(t <= RL));
    end
    acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'd0;
    for (int k = 1; k <= 2; k++) begin
      tick();
      if (k == 1) acc_strobe = 1'b0;
      chk(int'(ras_on) == (k == 2 ? 1 : 0), "R9 precharge after refresh", int'(ras_on),
          (k == 2 ? 1 : 0));
    end
    acc_req = 1'b0;
    repeat (4) tick();

    // Competition: fresh refresh loses, aged refresh wins (limit 2).
    rfsh_req = 1'b1; acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'd2;
    tick();
    rfsh_req = 1'b0; acc_strobe = 1'b0;
    chk(ras_on == 4'h4 && !rfsh_busy, "R11 access beats fresh refresh", int'(ras_on), 4);
    repeat (12) tick();
    acc_req = 1'b0;
    tick();
    chk(ras_on == 0, "R6 end before competition", int'(ras_on), 0);
    acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'd3;
    tick();
    acc_strobe = 1'b0;
    chk(ras_on == 0 && !rfsh_busy, "R11 aged refresh wins, waits precharge", int'(ras_on), 0);
    tick();
    chk(ras_on == 4'hF && rfsh_busy, "R11 aged refresh runs", int'(ras_on), 15);
    begin
      int seen = -1;
      for (int n = 1; n <= 10; n++) begin
        tick();
        if (seen < 0 && ras_on == 4'h8) seen = n;
      end
      chk(seen == 5, "R11 held access resumes after refresh", seen, 5);
    end
    acc_req = 1'b0;
    repeat (4) tick();

    // Competition with limit at the age ceiling: access always wins.
    cfg_rf_age_lim = 3'd7;
    do_reset();
    rfsh_req = 1'b1; acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'd2;
    tick();
    rfsh_req = 1'b0; acc_strobe = 1'b0;
    chk(ras_on == 4'h4, "R11 access wins first", int'(ras_on), 4);
    repeat (12) tick();
    acc_req = 1'b0;
    tick();
    acc_strobe = 1'b1; acc_req = 1'b1; bank_sel = 2'd3;
    tick();
    acc_strobe = 1'b0;
    chk(ras_on == 4'h8 && !rfsh_busy, "R11 age not above limit, access wins", int'(ras_on), 8);
    acc_req = 1'b0;
    tick();
    chk(ras_on == 0, "R6 end before pending refresh", int'(ras_on), 0);
    tick();
    tick();
    chk(ras_on == 4'hF && rfsh_busy, "R10 pending refresh served", int'(ras_on), 15);
    repeat (6) tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule